// File: doc/BRIEF.md
# SDR SDRAM Command Protocol Monitor

This block listens passively to the command pins between a single-data-rate SDRAM controller and the memory device. On every rising clock edge it decides whether a command was issued and decodes it from the three strobes RASn, CASn and WEn. It then updates a small model of the device: which banks are open, which row each open bank holds, and the read latency and burst length last programmed into the mode register. It never drives the memory pins.

When the controller breaks one of the protocol rules, the monitor raises a one-cycle pulse on that rule's error bit. It also sets a matching sticky bit, which stays set until the clear input is asserted. A decoded command strobe (one bit per command code) and the open-bank vector are exported, so a bench or an on-chip debug path can follow the command stream.

Every output is registered. The result of the command sampled at clock edge N appears just after edge N and holds until edge N+1. The bank count and the address width are parameters.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: After reset every bank is closed, every row field is 0, all error pulses and sticky bits are 0, the command strobe is 0, the latency output is 2 and the burst output is 0.
- R2: A command is decoded only on an edge where cs_n is low and cke was high at the previous edge. Its code is {ras_n, cas_n, we_n}: 0 mode set, 1 refresh, 2 precharge, 3 activate, 4 write, 5 read, 6 unknown, 7 NOP. cmd_strobe bit <code> is 1 for that cycle; otherwise cmd_strobe is 0.
- R3: A mode set with ba equal to 0 and addr[10] equal to 0 is accepted. burst_len takes addr[2:0], and cas_lat takes addr[6:4] when that field is 2 or 3. A mode set with any other ba or with addr[10] set changes nothing.
- R4: An accepted mode set with any of addr bits 9, 8, 7 or 3 set raises error bit 1 (reserved field).
- R5: An accepted mode set whose addr[6:4] is not 2 or 3 raises error bit 2 (bad latency) and leaves cas_lat unchanged.
- R6: An activate opens the bank selected by ba and stores addr as its row, at open_rows[b*ADDR_W +: ADDR_W]. An activate to a bank that is already open raises error bit 3, and the bank still takes the new row.
- R7: A precharge with addr[10] set closes every bank. With addr[10] clear it closes only the bank selected by ba.
- R8: A read or write to a closed bank raises error bit 4.
- R9: A read or write with addr[10] set (auto-precharge) raises error bit 5.
- R10: A write while dq_oe is 0, or a read while dq_oe is 1, raises error bit 6.
- R11: Command code 6 raises error bit 0. Refresh and NOP raise no error and change no bank state.
- R12: err_pulse shows the errors of the last decoded edge for exactly one cycle. err_sticky ORs in every pulse and keeps it until an edge where clr is 1. At such an edge the old sticky bits are dropped, but errors from that same edge are still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Clears the sticky error bits |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| addr | input | ADDR_W | Address bus (bit 10 is the all-banks / auto-precharge flag) |
| dq_oe | input | 1 | Controller data output enable |
| cmd_strobe | output | 8 | One-hot decoded command, bit index = code |
| bank_open | output | BANKS | Open flag per bank |
| open_rows | output | BANKS*ADDR_W | Stored row per bank |
| cas_lat | output | 3 | Read latency in use |
| burst_len | output | 3 | Programmed burst field |
| err_pulse | output | 7 | Per-rule error, one cycle |
| err_sticky | output | 7 | Per-rule error, held until clear |

## Verification
On every cycle the assertions check the following: the command strobe never has more than one bit set; no command is decoded when cke was low two edges earlier; the latency output is always 2 or 3; a precharge to all banks leaves every bank closed; and sticky bits never fall without a clear and always cover the current pulse. The directed scenarios are needed to show the rest: which exact error bit each rule violation raises, that a rejected mode set leaves the latency and burst fields alone, that a repeated activate overwrites the stored row, and that a clear issued together with a new error keeps only the new error.

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor #(
  parameter int BANKS  = 4,
  parameter int ADDR_W = 13,
  localparam int BA_W  = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int NERR  = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      cke,
  input  logic                      cs_n,
  input  logic                      ras_n,
  input  logic                      cas_n,
  input  logic                      we_n,
  input  logic [BA_W-1:0]           ba,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      dq_oe,
  output logic [7:0]                cmd_strobe,
  output logic [BANKS-1:0]          bank_open,
  output logic [BANKS*ADDR_W-1:0]   open_rows,
  output logic [2:0]                cas_lat,
  output logic [2:0]                burst_len,
  output logic [NERR-1:0]           err_pulse,
  output logic [NERR-1:0]           err_sticky
);

  logic           cke_q;
  logic [7:0]     dec;
  logic [NERR-1:0] err_now;

  assign dec = (!cs_n && cke_q) ? (8'b1 << {ras_n, cas_n, we_n}) : 8'b0;

  wire is_pre = dec[2];
  wire is_act = dec[3];
  wire is_wr  = dec[4];
  wire is_rd  = dec[5];
  wire is_rw  = is_wr | is_rd;
  wire mrs_ok = dec[0] && (ba == '0) && !addr[10];
  wire lat_ok = (addr[6:4] == 3'd2) || (addr[6:4] == 3'd3);
  wire sel_open = bank_open[ba];

  assign err_now[0] = dec[6];
  assign err_now[1] = mrs_ok && (addr[9] | addr[8] | addr[7] | addr[3]);
  assign err_now[2] = mrs_ok && !lat_ok;
  assign err_now[3] = is_act && sel_open;
  assign err_now[4] = is_rw && !sel_open;
  assign err_now[5] = is_rw && addr[10];
  assign err_now[6] = (is_wr && !dq_oe) || (is_rd && dq_oe);

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic              open_q;
      logic [ADDR_W-1:0] row_q;
      wire hit = (ba == BA_W'(b));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          open_q <= 1'b0;
          row_q  <= '0;
        end else if (is_act && hit) begin
          open_q <= 1'b1;
          row_q  <= addr;
        end else if (is_pre && (addr[10] || hit)) begin
          open_q <= 1'b0;
        end
      end
      assign bank_open[b] = open_q;
      assign open_rows[b*ADDR_W +: ADDR_W] = row_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q      <= 1'b0;
      cmd_strobe <= '0;
      cas_lat    <= 3'd2;
      burst_len  <= 3'd0;
      err_pulse  <= '0;
      err_sticky <= '0;
    end else begin
      cke_q      <= cke;
      cmd_strobe <= dec;
      err_pulse  <= err_now;
      err_sticky <= (err_sticky & ~{NERR{clr}}) | err_now;
      if (mrs_ok) begin
        burst_len <= addr[2:0];
        if (lat_ok) cas_lat <= addr[6:4];
      end
    end
  end

  a_r2_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_strobe));

  a_r2_cke_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> ##2 (cmd_strobe == 8'h00));

  a_r5_latency_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat == 3'd2) || (cas_lat == 3'd3));

  a_r7_precharge_all: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe[2] && $past(addr[10])) |-> (bank_open == '0));

  a_r12_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((~err_sticky & $past(err_sticky)) == '0));

  a_r12_sticky_covers: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_pulse & ~err_sticky) == '0));

endmodule

// File: tb/sdram_cmd_monitor_test.sv
module sdram_cmd_monitor_test;
  localparam int BANKS = 4;
  localparam int AW    = 13;

  logic clk = 0, rst_n = 0, clr = 0, cke = 1;
  logic cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, dq_oe = 0;
  logic [1:0] ba = 0;
  logic [AW-1:0] addr = 0;
  logic [7:0] cmd_strobe;
  logic [BANKS-1:0] bank_open;
  logic [BANKS*AW-1:0] open_rows;
  logic [2:0] cas_lat, burst_len;
  logic [6:0] err_pulse, err_sticky;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sdram_cmd_monitor #(.BANKS(BANKS), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .dq_oe(dq_oe), .cmd_strobe(cmd_strobe), .bank_open(bank_open),
    .open_rows(open_rows), .cas_lat(cas_lat), .burst_len(burst_len),
    .err_pulse(err_pulse), .err_sticky(err_sticky));

  task automatic chk(string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, got, exp);
    end
  endtask

  // Drive one command at a falling edge; results are valid at the next falling edge.
  task automatic issue(input logic [2:0] code, input logic [1:0] b,
                       input logic [AW-1:0] a, input logic oe,
                       input logic sel = 1'b0, input logic cl = 1'b0);
    @(negedge clk);
    cs_n = sel; {ras_n, cas_n, we_n} = code; ba = b; addr = a; dq_oe = oe; clr = cl;
    @(negedge clk);
    cs_n = 1; {ras_n, cas_n, we_n} = 3'b111; clr = 0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  function automatic logic [AW-1:0] row_of(int b);
    return open_rows[b*AW +: AW];
  endfunction

  task automatic t_reset();
    chk("R1 strobe", cmd_strobe, 0);
    chk("R1 open", bank_open, 0);
    chk("R1 rows", open_rows, 0);
    chk("R1 cas", cas_lat, 2);
    chk("R1 burst", burst_len, 0);
    chk("R1 pulse", err_pulse, 0);
    chk("R1 sticky", err_sticky, 0);
  endtask

  task automatic t_mode();
    issue(3'd0, 0, 13'h032, 0);
    chk("R2 mode strobe", cmd_strobe, 8'h01);
    chk("R3 cas 3", cas_lat, 3);
    chk("R3 burst 2", burst_len, 2);
    chk("R3 no err", err_pulse, 0);
    issue(3'd0, 1, 13'h023, 0);
    chk("R3 ba!=0 cas", cas_lat, 3);
    chk("R3 ba!=0 burst", burst_len, 2);
    issue(3'd0, 0, 13'h421, 0);
    chk("R3 a10 cas", cas_lat, 3);
    chk("R3 a10 burst", burst_len, 2);
    issue(3'd0, 0, 13'h3A1, 0);
    chk("R4 reserved pulse", err_pulse, 7'h02);
    chk("R4 accepted cas", cas_lat, 2);
    chk("R4 accepted burst", burst_len, 1);
    issue(3'd0, 0, 13'h053, 0);
    chk("R5 bad latency pulse", err_pulse, 7'h04);
    chk("R5 cas kept", cas_lat, 2);
    chk("R5 burst taken", burst_len, 3);
    do_clear();
    chk("R12 cleared", err_sticky, 0);
  endtask

  task automatic t_gate();
    @(negedge clk); cke = 0;
    @(negedge clk); cke = 1;
    cs_n = 0; {ras_n, cas_n, we_n} = 3'd3; ba = 0; addr = 13'h011;
    @(negedge clk); cs_n = 1; {ras_n, cas_n, we_n} = 3'b111;
    chk("R2 cke low strobe", cmd_strobe, 0);
    chk("R2 cke low open", bank_open, 0);
    issue(3'd3, 0, 13'h011, 0, 1'b1);
    chk("R2 cs high strobe", cmd_strobe, 0);
    chk("R2 cs high open", bank_open, 0);
  endtask

  task automatic t_activate();
    issue(3'd3, 1, 13'h123, 0);
    chk("R2 act strobe", cmd_strobe, 8'h08);
    chk("R6 open b1", bank_open, 4'b0010);
    chk("R6 row b1", row_of(1), 13'h123);
    chk("R6 no err", err_pulse, 0);
    issue(3'd3, 1, 13'h055, 0);
    chk("R6 reopen pulse", err_pulse, 7'h08);
    chk("R6 new row", row_of(1), 13'h055);
    chk("R6 still open", bank_open, 4'b0010);
    do_clear();
  endtask

  task automatic t_precharge();
    issue(3'd3, 2, 13'h0AA, 0);
    issue(3'd2, 1, 13'h000, 0);
    chk("R7 single", bank_open, 4'b0100);
    issue(3'd3, 0, 13'h001, 0);
    chk("R7 reopen b0", bank_open, 4'b0101);
    issue(3'd2, 3, 13'h400, 0);
    chk("R7 all", bank_open, 0);
    chk("R7 no err", err_sticky, 0);
  endtask

  task automatic t_access();
    issue(3'd4, 3, 13'h010, 1);
    chk("R8 closed write", err_pulse, 7'h10);
    issue(3'd5, 3, 13'h010, 0);
    chk("R8 closed read", err_pulse, 7'h10);
    issue(3'd3, 3, 13'h077, 0);
    issue(3'd4, 3, 13'h010, 0);
    chk("R10 write oe off", err_pulse, 7'h40);
    issue(3'd5, 3, 13'h010, 1);
    chk("R10 read oe on", err_pulse, 7'h40);
    issue(3'd5, 3, 13'h410, 0);
    chk("R9 read autopre", err_pulse, 7'h20);
    issue(3'd4, 3, 13'h410, 1);
    chk("R9 write autopre", err_pulse, 7'h20);
    chk("R9 bank stays open", bank_open, 4'b1000);
    issue(3'd4, 3, 13'h010, 1);
    chk("R2 write strobe", cmd_strobe, 8'h10);
    chk("R8 legal write", err_pulse, 0);
    issue(3'd5, 3, 13'h010, 0);
    chk("R2 read strobe", cmd_strobe, 8'h20);
    chk("R8 legal read", err_pulse, 0);
    do_clear();
  endtask

  task automatic t_other();
    issue(3'd6, 0, 13'h000, 0);
    chk("R11 unknown strobe", cmd_strobe, 8'h40);
    chk("R11 unknown pulse", err_pulse, 7'h01);
    issue(3'd1, 0, 13'h000, 0);
    chk("R11 refresh strobe", cmd_strobe, 8'h02);
    chk("R11 refresh no err", err_pulse, 0);
    chk("R11 refresh bank", bank_open, 4'b1000);
    issue(3'd7, 0, 13'h000, 0);
    chk("R11 nop strobe", cmd_strobe, 8'h80);
    chk("R11 nop bank", bank_open, 4'b1000);
  endtask

  task automatic t_sticky();
    issue(3'd4, 0, 13'h000, 1);
    chk("R12 accumulate", err_sticky, 7'h11);
    idle();
    chk("R12 pulse gone", err_pulse, 0);
    chk("R12 sticky held", err_sticky, 7'h11);
    issue(3'd6, 0, 13'h000, 0, 1'b0, 1'b1);
    chk("R12 clear with new err", err_sticky, 7'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mode();
    t_gate();
    t_activate();
    t_precharge();
    t_access();
    t_other();
    t_sticky();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule